// File: doc/BRIEF.md
# Sixteen-times oversampled serial receiver with noise detection

This block receives asynchronous serial frames on a single line. It looks at the line only on the cycles where a sample-tick enable is high, and that tick runs at sixteen times the bit rate. Each bit time is therefore split into sixteen samples, numbered 1 to 16. The line first passes through a two-flop synchroniser. A frame begins at a falling edge seen on the ticked samples, and that edge sample is sample 1 of the start bit.

The start bit is checked at fixed sample slots. Each later bit is resolved by a majority vote over its three centre samples. A per-frame noise flag collects every suspicious observation. When the stop bit has been voted, the block presents the byte, the noise flag and a framing-error flag, together with a one-cycle valid strobe. Baud generation, buffering and parity sit outside the block.

Top module: `uart_os16_rx`

## Requirements
- R1: The line passes through a two-flop synchroniser and is observed only on cycles where `sample_tick` is high. Line activity between ticks has no effect on reception.
- R2: While idle, a frame starts when a ticked sample reads 0 and the previous ticked sample read 1. A line held low since reset starts nothing.
- R3: The start edge is clean only if the three ticked samples just before it were all 1. Otherwise the frame's noise flag is set. The history counts as all 0 after reset.
- R4: If start-bit sample 3, 5 or 7 reads 1, the noise flag is set. Start-bit samples 2, 4, 6 and 11 to 16 are ignored.
- R5: If any of start-bit samples 8, 9 or 10 reads 1, the noise flag is set.
- R6: If the majority of start-bit samples 8, 9 and 10 is 1, the start is false. The receiver returns to idle after sample 10, and no strobe and no byte are produced.
- R7: The frame has 8 data bits after the start bit, least significant bit first, and `rx_data[0]` is the first data bit. Each bit value is the majority of its samples 8, 9 and 10.
- R8: A data bit whose samples 8, 9 and 10 are not all equal sets the noise flag. Its other samples are ignored.
- R9: The stop bit is the majority of its samples 8, 9 and 10. A stop value of 0 sets `frame_err`. A split among those three samples sets the noise flag.
- R10: `rx_valid` is high for exactly one cycle, in the cycle after the tick that takes stop-bit sample 10. `rx_data`, `noise_err` and `frame_err` then hold until the next frame. `noise_err` and `frame_err` are cleared when the next start edge is detected. After reset all outputs are 0.
- R11: Frames from a transmitter whose bit time differs by about 3% from the receiver's are received with the correct byte and no noise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Serial line, idle high |
| sample_tick | input | 1 | One-cycle enable at sixteen times the bit rate |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |
| noise_err | output | 1 | Noise seen in the last frame |
| frame_err | output | 1 | Stop bit read as 0 in the last frame |

## Verification
Frames are sent as explicit per-sample streams. Single-sample upsets in the start slots 3/5/7 and 8/9/10, and in the ignored slots, separate the slots that are checked from those that are not. A single upset in a data bit's centre sets noise but keeps the value. A double upset flips the bit, which shows that a majority is taken rather than one sample. Short low pulses and a start with two high centre samples separate a false start from a noisy but valid start. A stop bit driven low or split exercises the framing path. An edge after a low-held line tests the history rule. Streams whose bits are stretched or shortened by one sample every second bit confirm that centre sampling tolerates drift.

// File: rtl/uart_os16_rx_pkg.sv
package uart_os16_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync_chain.sv
module rx_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= {STAGES{RST_VAL}};
    end else begin
      ff_q <= ff_d;
    end
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/rx_edge_hist.sv
module rx_edge_hist #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  output logic fall_o,
  output logic clean_o
);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (tick) begin
      hist_d = {hist_q[DEPTH-2:0], rx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  // falling edge: newest prior sample high, current sample low
  assign fall_o  = tick & ~rx & hist_q[0];
  assign clean_o = &hist_q;

endmodule

// File: rtl/rx_centre_vote.sv
module rx_centre_vote
  import uart_os16_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int IDXW = $clog2(OVS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [IDXW-1:0] idx,
  input  logic            rx,
  output logic            decide_o,
  output logic            bit_o,
  output logic            split_o,
  output logic            any_one_o
);

  localparam logic [IDXW-1:0] I_A = IDXW'(OVS/2 - 1);
  localparam logic [IDXW-1:0] I_B = IDXW'(OVS/2);
  localparam logic [IDXW-1:0] I_C = IDXW'(OVS/2 + 1);

  logic a_q, a_d;
  logic b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (tick && (idx == I_A)) a_d = rx;
    if (tick && (idx == I_B)) b_d = rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // third sample is taken live on the deciding tick
  assign decide_o  = tick && (idx == I_C);
  assign bit_o     = maj3(a_q, b_q, rx);
  assign split_o   = ~((a_q == b_q) && (b_q == rx));
  assign any_one_o = a_q | b_q | rx;

endmodule

// File: rtl/uart_os16_rx.sv
module uart_os16_rx
  import uart_os16_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_DEPTH  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_i,
  input  logic                 sample_tick,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 noise_err,
  output logic                 frame_err
);

  localparam int IDXW = $clog2(OVS);
  localparam int BITW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  // start-bit early check slots (samples 3, 5, 7 as zero-based indices)
  localparam logic [IDXW-1:0] E1 = IDXW'(OVS/8);
  localparam logic [IDXW-1:0] E2 = IDXW'(OVS/4);
  localparam logic [IDXW-1:0] E3 = IDXW'(3*OVS/8);
  localparam logic [BITW-1:0] LAST_BIT = BITW'(DATA_BITS - 1);

  logic rst_sync_n;
  logic rx_s;

  rx_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  rx_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (rx_i),
    .q     (rx_s)
  );

  logic fall, clean;

  rx_edge_hist #(.DEPTH(EDGE_DEPTH)) u_hist (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (sample_tick),
    .rx      (rx_s),
    .fall_o  (fall),
    .clean_o (clean)
  );

  rx_state_e            state_q, state_d;
  logic [IDXW-1:0]      idx_q, idx_d;
  logic [BITW-1:0]      bitn_q, bitn_d;
  logic [DATA_BITS-1:0] shreg_q, shreg_d;
  logic                 noise_q, noise_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 nout_q, nout_d;
  logic                 ferr_q, ferr_d;
  logic                 valid_q, valid_d;

  logic [IDXW-1:0] cur_idx;
  logic            decide, vbit, split, any_one, early_hit;

  // index of the sample taken on the current tick
  assign cur_idx = (state_q == ST_IDLE) ? '0 : (idx_q + 1'b1);

  rx_centre_vote #(.OVS(OVS), .IDXW(IDXW)) u_vote (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (sample_tick),
    .idx       (cur_idx),
    .rx        (rx_s),
    .decide_o  (decide),
    .bit_o     (vbit),
    .split_o   (split),
    .any_one_o (any_one)
  );

  assign early_hit = rx_s && ((cur_idx == E1) || (cur_idx == E2) || (cur_idx == E3));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bitn_d  = bitn_q;
    shreg_d = shreg_q;
    noise_d = noise_q;
    data_d  = data_q;
    nout_d  = nout_q;
    ferr_d  = ferr_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_START;
          idx_d   = '0;
          noise_d = ~clean;
          nout_d  = 1'b0;
          ferr_d  = 1'b0;
        end
      end
      ST_START: begin
        if (sample_tick) begin
          idx_d = cur_idx;
          if (early_hit) noise_d = 1'b1;
          if (decide) begin
            if (any_one) noise_d = 1'b1;
            if (vbit)    state_d = ST_IDLE;
          end
          if (cur_idx == '0) begin
            state_d = ST_DATA;
            bitn_d  = '0;
          end
        end
      end
      ST_DATA: begin
        if (sample_tick) begin
          idx_d = cur_idx;
          if (decide) begin
            shreg_d = {vbit, shreg_q[DATA_BITS-1:1]};
            if (split) noise_d = 1'b1;
          end
          if (cur_idx == '0) begin
            if (bitn_q == LAST_BIT) state_d = ST_STOP;
            else                    bitn_d  = bitn_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (sample_tick && decide) begin
          data_d  = shreg_q;
          nout_d  = noise_q | split;
          ferr_d  = ~vbit;
          valid_d = 1'b1;
          state_d = ST_IDLE;
        end else if (sample_tick) begin
          idx_d = cur_idx;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      noise_q <= 1'b0;
      data_q  <= '0;
      nout_q  <= 1'b0;
      ferr_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bitn_q  <= bitn_d;
      shreg_q <= shreg_d;
      noise_q <= noise_d;
      data_q  <= data_d;
      nout_q  <= nout_d;
      ferr_q  <= ferr_d;
      valid_q <= valid_d;
    end
  end

  assign rx_data   = data_q;
  assign rx_valid  = valid_q;
  assign noise_err = nout_q;
  assign frame_err = ferr_q;

endmodule

// File: rtl/uart_os16_rx_chk.sv
module uart_os16_rx_chk
  import uart_os16_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_tick,
  input logic                 rx_valid,
  input logic                 noise_err,
  input logic                 frame_err,
  input logic [DATA_BITS-1:0] rx_data,
  input rx_state_e            state
);

  // R10: strobe lasts one cycle
  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: strobe follows a ticked sample
  a_r10_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sample_tick));

  // R10: byte holds between strobes
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  // R6: a strobe only ever comes out of the stop bit
  a_r6_valid_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(state) == ST_STOP));

  // R9: framing error only appears with the strobe
  a_r9_ferr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> rx_valid);

  // R8: noise flag only appears with the strobe
  a_r8_noise_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noise_err) |-> rx_valid);

  // R1: receiver state moves only on ticked cycles
  a_r1_state_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_tick) |-> $stable(state));

endmodule

bind uart_os16_rx uart_os16_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sample_tick (sample_tick),
  .rx_valid    (rx_valid),
  .noise_err   (noise_err),
  .frame_err   (frame_err),
  .rx_data     (rx_data),
  .state       (state_q)
);

// File: tb/uart_os16_rx_tb.sv
`timescale 1ns/1ps
module uart_os16_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx;
  logic       tick;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       noise_err;
  logic       frame_err;

  always #2.5 clk = ~clk;

  uart_os16_rx u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx),
    .sample_tick (tick),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .noise_err   (noise_err),
    .frame_err   (frame_err)
  );

  typedef struct {
    logic [7:0] d;
    logic       n;
    logic       f;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  int   valid_cnt = 0;
  logic prev_v = 1'b0;
  logic s [0:199];
  int   slen;
  logic [2:0] hist_tb;

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v) chk(!rx_valid, "R10", "strobe width", rx_valid, 0);
      prev_v = rx_valid;
      if (rx_valid) begin
        valid_cnt++;
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rx_data == e.d,   e.tag, "data",  rx_data,   e.d);
          chk(noise_err == e.n, e.tag, "noise", noise_err, e.n);
          chk(frame_err == e.f, e.tag, "ferr",  frame_err, e.f);
        end
      end
    end
  end

  task automatic one_sample(input logic v);
    rx   = v;
    tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    hist_tb = {hist_tb[1:0], v};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) one_sample(1'b1);
  endtask

  task automatic build(input logic [7:0] d, input logic stopv);
    slen = 176;
    for (int i = 0; i < 176; i++) begin
      int k;
      k = i / 16;
      if (k == 0)      s[i] = 1'b0;
      else if (k <= 8) s[i] = d[k-1];
      else if (k == 9) s[i] = stopv;
      else             s[i] = 1'b1;
    end
  endtask

  task automatic build_drift(input logic [7:0] d, input bit fast);
    int pos;
    pos = 0;
    for (int k = 0; k < 10; k++) begin
      int len;
      logic v;
      len = 16;
      if (k % 2 == 1) len = fast ? 15 : 17;
      v = (k == 0) ? 1'b0 : ((k <= 8) ? d[k-1] : 1'b1);
      for (int j = 0; j < len; j++) begin
        s[pos] = v;
        pos++;
      end
    end
    for (int i = pos; i < 180; i++) s[i] = 1'b1;
    slen = 180;
  endtask

  task automatic flip(input int bitn, input int slot);
    s[16*bitn + slot - 1] = ~s[16*bitn + slot - 1];
  endtask

  // model from the requirements, then drive the stream
  task automatic run_stream(input string tag);
    logic       n, f, fs;
    logic [7:0] d;
    n  = (hist_tb != 3'b111);
    n  = n | s[2] | s[4] | s[6] | s[7] | s[8] | s[9];
    fs = maj(s[7], s[8], s[9]);
    d  = '0;
    for (int k = 0; k < 8; k++) begin
      int b;
      b = 16 * (k + 1);
      d[k] = maj(s[b+7], s[b+8], s[b+9]);
      if (!((s[b+7] == s[b+8]) && (s[b+8] == s[b+9]))) n = 1'b1;
    end
    if (!((s[151] == s[152]) && (s[152] == s[153]))) n = 1'b1;
    f = ~maj(s[151], s[152], s[153]);
    if (!fs) begin
      exp_t e;
      e.d = d; e.n = n; e.f = f; e.tag = tag;
      sb.push_back(e);
    end
    for (int i = 0; i < slen; i++) begin
      one_sample(s[i]);
      if (i == 20 && slen > 21) begin
        chk(!noise_err, "R10", "noise cleared at start", noise_err, 0);
        chk(!frame_err, "R10", "ferr cleared at start", frame_err, 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_run();
  end

  initial begin : main
    int vc;
    rst_n   = 1'b0;
    rx      = 1'b1;
    tick    = 1'b0;
    hist_tb = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state (R10)
    chk(!rx_valid,      "R10", "reset valid", rx_valid, 0);
    chk(rx_data == 8'h0, "R10", "reset data", rx_data, 0);
    chk(!noise_err,     "R10", "reset noise", noise_err, 0);
    chk(!frame_err,     "R10", "reset ferr", frame_err, 0);

    // R2: line low since reset starts nothing
    for (int i = 0; i < 6; i++) one_sample(1'b0);
    chk(valid_cnt == 0, "R2", "low line no frame", valid_cnt, 0);
    one_sample(1'b1);
    // R3: edge after only one high sample is not clean
    build(8'hA5, 1'b1); run_stream("R3"); idle(4);

    build(8'h3C, 1'b1); run_stream("R7"); idle(4);
    build(8'h81, 1'b1); flip(4, 9); run_stream("R8"); idle(4);
    build(8'h0F, 1'b1); flip(3, 8); flip(3, 10); run_stream("R7"); idle(4);
    build(8'h66, 1'b1); flip(2, 4); flip(5, 14); flip(7, 1); run_stream("R8"); idle(4);
    build(8'h12, 1'b1); flip(0, 5); run_stream("R4"); idle(4);
    build(8'h34, 1'b1); flip(0, 2); flip(0, 12); run_stream("R4"); idle(4);
    build(8'h56, 1'b1); flip(0, 9); run_stream("R5"); idle(4);
    build(8'hE7, 1'b1); flip(0, 3); run_stream("R4"); idle(4);

    // R6: false starts
    vc = valid_cnt;
    slen = 16;
    for (int i = 0; i < 16; i++) s[i] = 1'b1;
    for (int i = 0; i < 7; i++) s[i] = 1'b0;
    s[9] = 1'b0;
    run_stream("R6"); idle(4);
    chk(valid_cnt == vc, "R6", "majority-high start dropped", valid_cnt, vc);
    for (int i = 0; i < 16; i++) s[i] = 1'b1;
    s[0] = 1'b0;
    run_stream("R6"); idle(4);
    chk(valid_cnt == vc, "R6", "low pulse dropped", valid_cnt, vc);

    // R9: stop bit
    build(8'h99, 1'b0); run_stream("R9"); idle(4);
    build(8'hC4, 1'b1); flip(9, 9); run_stream("R9"); idle(4);
    build(8'h5D, 1'b1); flip(9, 8); flip(9, 10); run_stream("R9"); idle(4);

    // R10: byte held while idle
    repeat (50) @(negedge clk);
    chk(rx_data == 8'h5D, "R10", "byte held", rx_data, 8'h5D);
    chk(frame_err,        "R10", "ferr held", frame_err, 1);

    // R1: activity between ticks is invisible
    vc = valid_cnt;
    for (int g = 0; g < 5; g++) begin
      rx = 1'b0;
      @(negedge clk);
      rx = 1'b1;
      repeat (3) @(negedge clk);
    end
    idle(2);
    chk(valid_cnt == vc, "R1", "untick glitch ignored", valid_cnt, vc);
    build(8'hB2, 1'b1); run_stream("R1"); idle(4);

    // R11: drifting transmitter
    build_drift(8'h5A, 1'b0); run_stream("R11"); idle(4);
    build_drift(8'hC3, 1'b1); run_stream("R11"); idle(4);

    repeat (8) @(negedge clk);
    chk(sb.size() == 0, "R10", "all frames delivered", sb.size(), 0);
    finish_run();
  end

endmodule